// File: doc/BRIEF.md
# Link Width Negotiation Controller

This controller decides how an eight-lane serial port, built from two four-lane halves, is grouped into links and which lane count each link runs at. After reset or a retrain request, every half that sees a receiver reports the identifier of the partner it found. If both halves report the same partner, they are joined into one eight-lane link. Otherwise each half stays a separate link of up to four lanes.

Each link then works through a series of training attempts. The first attempt uses the widest width that both ends support. When an attempt fails, or brings no result before a programmable timeout, the next narrower supported width is tried. A one-lane link counts as a success. A failure at one lane leaves the link in a link-down state until the next retrain. The grouping, the width in use or reached, and the trained and link-down flags stay on the outputs, so that software can later examine the partner.

Lane deskew, symbol coding and electrical detection sit outside this block. Their outcomes reach it as simple per-half detect, identifier and pass/fail signals.

Top module: `lwn_ctrl`

## Requirements
- R1: Once reset has been released, and in the cycle after a retrain request, all of the following are 0: merged_o, trying_o, trained_o and down_o. A retrain discards earlier results and runs grouping again.
- R2: If both halves are detected and both report valid, equal identifiers, merged_o is 1. Link 0 then carries the eight-lane link, and link 1 stays idle with width1_o equal to 0.
- R3: If the identifiers differ, each half runs its own attempt sequence and reaches its own result. A half whose lane_det_i bit is 0 stays idle (no attempt, no trained, no link-down).
- R4: Widths are one-hot: bit 3 is x8, bit 2 is x4, bit 1 is x2 and bit 0 is x1. The first attempt uses the highest set bit of LOCAL_MASK AND the partner mask, with x1 always treated as supported. A link that is not merged never uses x8.
- R5: After a failed attempt, the next attempt uses the next lower bit of the eligible mask, skipping any width that is not supported by both ends.
- R6: If an attempt sees neither pass nor fail for tmo_i cycles, it counts as failed (a tmo_i of 0 acts as 1).
- R7: A pass sets trained_o for that link. The width then stays fixed until a retrain, and a pass at x1 counts as success.
- R8: A failure at x1 sets down_o for that link, with width 0. The link makes no further attempts until a retrain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retrain_i | input | 1 | Restart grouping and training |
| lane_det_i | input | 2 | Receiver present, per half |
| id_vld_i | input | 2 | Partner identifier valid, per half |
| id0_i | input | ID_W | Partner identifier seen by half 0 |
| id1_i | input | ID_W | Partner identifier seen by half 1 |
| pmask0_i | input | 4 | Partner width mask seen by half 0 |
| pmask1_i | input | 4 | Partner width mask seen by half 1 |
| tmo_i | input | TMO_W | Attempt timeout in cycles |
| pass_i | input | 2 | Attempt passed, per link |
| fail_i | input | 2 | Attempt failed, per link |
| merged_o | output | 1 | Halves joined into one eight-lane link |
| width0_o | output | 4 | Current or final width of link 0, one-hot |
| width1_o | output | 4 | Current or final width of link 1, one-hot |
| trying_o | output | 2 | Attempt in progress, per link |
| trained_o | output | 2 | Link trained, per link |
| down_o | output | 2 | Link down after x1 failure, per link |

## Verification
The bench builds the controller with LOCAL_MASK set to 4'b1101, which leaves out x2. A fail at x4 therefore has to land on x1, and this exposes the skip of unsupported widths. With ID_W at 4 and TMO_W at 6, a silent partner can run into a five-cycle timeout, and the exact duration of the attempt is counted. A partner model answers each attempt after a fixed delay and can be told to fail, or to stay silent, at chosen widths. The sequence of attempted widths is logged per link and compared against the expected sequence.

// File: rtl/lwn_pkg.sv
package lwn_pkg;
   localparam int NW = 4;
   typedef logic [NW-1:0] wmask_t;
   localparam wmask_t W_X1 = 4'b0001;
   localparam wmask_t W_HALF_CAP = 4'b0111;

   typedef enum logic [1:0] {ST_IDLE, ST_TRY, ST_UP, ST_DOWN} step_st_e;
   typedef enum logic {GR_WAIT, GR_DONE} grp_st_e;

   function automatic wmask_t top_bit(input wmask_t m);
      wmask_t r;
      r = '0;
      for (int i = 0; i < NW; i++)
         if (m[i]) r = wmask_t'(1) << i;
      return r;
   endfunction
endpackage

// File: rtl/lwn_mask_sel.sv
module lwn_mask_sel
   import lwn_pkg::*;
#(
   parameter wmask_t LOCAL_MASK = 4'b1111,
   parameter bit     ALLOW_X8   = 1'b1
) (
   input  wmask_t pmask_i,
   output wmask_t elig_o
);
   wmask_t common;
   assign common = LOCAL_MASK & pmask_i;

   generate
      if (ALLOW_X8) begin : g_full
         assign elig_o = common | W_X1;
      end else begin : g_half
         assign elig_o = (common & W_HALF_CAP) | W_X1;
      end
   endgenerate
endmodule

// File: rtl/lwn_group.sv
module lwn_group
   import lwn_pkg::*;
#(
   parameter int ID_W        = 8,
   parameter bit ALLOW_MERGE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            restart_i,
   input  logic [1:0]      det_i,
   input  logic [1:0]      vld_i,
   input  logic [ID_W-1:0] id0_i,
   input  logic [ID_W-1:0] id1_i,
   output logic            merged_o,
   output logic [1:0]      active_o,
   output logic            start_o
);
   grp_st_e st;
   logic    ready;
   logic    same;

   assign ready = (det_i != 2'b00) && ((vld_i | ~det_i) == 2'b11);

   generate
      if (ALLOW_MERGE) begin : g_merge
         assign same = (det_i == 2'b11) && (vld_i == 2'b11) && (id0_i == id1_i);
      end else begin : g_nomerge
         assign same = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || restart_i) begin
         st       <= GR_WAIT;
         merged_o <= 1'b0;
         active_o <= 2'b00;
         start_o  <= 1'b0;
      end else begin
         start_o <= 1'b0;
         if (st == GR_WAIT && ready) begin
            st       <= GR_DONE;
            merged_o <= same;
            active_o <= same ? 2'b01 : det_i;
            start_o  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/lwn_stepper.sv
module lwn_stepper
   import lwn_pkg::*;
#(
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             abort_i,
   input  logic             start_i,
   input  wmask_t           elig_i,
   input  logic             pass_i,
   input  logic             fail_i,
   input  logic [TMO_W-1:0] tmo_i,
   output wmask_t           width_o,
   output logic             trying_o,
   output logic             trained_o,
   output logic             down_o
);
   step_st_e         st;
   wmask_t           remain;
   wmask_t           rest;
   logic [TMO_W-1:0] cnt;
   logic [TMO_W-1:0] lim;
   logic             expire;

   assign lim    = (tmo_i == '0) ? TMO_W'(1) : tmo_i;
   assign expire = (cnt == lim - TMO_W'(1));
   assign rest   = remain & ~width_o;

   always_ff @(posedge clk) begin
      if (!rst_n || abort_i) begin
         st      <= ST_IDLE;
         remain  <= '0;
         width_o <= '0;
         cnt     <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (start_i) begin
                  remain  <= elig_i;
                  width_o <= top_bit(elig_i);
                  cnt     <= '0;
                  st      <= ST_TRY;
               end
            end
            ST_TRY: begin
               if (pass_i) begin
                  st <= ST_UP;
               end else if (fail_i || expire) begin
                  remain  <= rest;
                  width_o <= top_bit(rest);
                  cnt     <= '0;
                  if (rest == '0) st <= ST_DOWN;
               end else begin
                  cnt <= cnt + TMO_W'(1);
               end
            end
            default: ;
         endcase
      end
   end

   assign trying_o  = (st == ST_TRY);
   assign trained_o = (st == ST_UP);
   assign down_o    = (st == ST_DOWN);
endmodule

// File: rtl/lwn_ctrl.sv
module lwn_ctrl
   import lwn_pkg::*;
#(
   parameter wmask_t LOCAL_MASK  = 4'b1111,
   parameter int     ID_W        = 8,
   parameter int     TMO_W       = 8,
   parameter bit     ALLOW_MERGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retrain_i,
   input  logic [1:0]       lane_det_i,
   input  logic [1:0]       id_vld_i,
   input  logic [ID_W-1:0]  id0_i,
   input  logic [ID_W-1:0]  id1_i,
   input  logic [3:0]       pmask0_i,
   input  logic [3:0]       pmask1_i,
   input  logic [TMO_W-1:0] tmo_i,
   input  logic [1:0]       pass_i,
   input  logic [1:0]       fail_i,
   output logic             merged_o,
   output logic [3:0]       width0_o,
   output logic [3:0]       width1_o,
   output logic [1:0]       trying_o,
   output logic [1:0]       trained_o,
   output logic [1:0]       down_o
);
   generate
      if (LOCAL_MASK[0] != 1'b1) begin : g_bad_mask
         $error("lwn_ctrl: LOCAL_MASK must include x1");
      end
      if (TMO_W < 2) begin : g_bad_tmo
         $error("lwn_ctrl: TMO_W must be at least 2");
      end
      if (ID_W < 1) begin : g_bad_id
         $error("lwn_ctrl: ID_W must be at least 1");
      end
   endgenerate

   logic       merged;
   logic [1:0] active;
   logic       start;

   lwn_group #(.ID_W(ID_W), .ALLOW_MERGE(ALLOW_MERGE)) u_group (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart_i (retrain_i),
      .det_i     (lane_det_i),
      .vld_i     (id_vld_i),
      .id0_i     (id0_i),
      .id1_i     (id1_i),
      .merged_o  (merged),
      .active_o  (active),
      .start_o   (start)
   );

   wmask_t pmask [2];
   wmask_t elig_half [2];
   wmask_t elig_full;
   wmask_t elig_link [2];
   wmask_t width [2];

   assign pmask[0] = pmask0_i;
   assign pmask[1] = pmask1_i;

   lwn_mask_sel #(.LOCAL_MASK(LOCAL_MASK), .ALLOW_X8(1'b1)) u_sel_full (
      .pmask_i (pmask[0]),
      .elig_o  (elig_full)
   );

   assign elig_link[0] = merged ? elig_full : elig_half[0];
   assign elig_link[1] = elig_half[1];

   generate
      for (genvar h = 0; h < 2; h++) begin : g_link
         lwn_mask_sel #(.LOCAL_MASK(LOCAL_MASK), .ALLOW_X8(1'b0)) u_sel_half (
            .pmask_i (pmask[h]),
            .elig_o  (elig_half[h])
         );

         lwn_stepper #(.TMO_W(TMO_W)) u_step (
            .clk       (clk),
            .rst_n     (rst_n),
            .abort_i   (retrain_i),
            .start_i   (start && active[h]),
            .elig_i    (elig_link[h]),
            .pass_i    (pass_i[h]),
            .fail_i    (fail_i[h]),
            .tmo_i     (tmo_i),
            .width_o   (width[h]),
            .trying_o  (trying_o[h]),
            .trained_o (trained_o[h]),
            .down_o    (down_o[h])
         );
      end
   endgenerate

   assign merged_o = merged;
   assign width0_o = width[0];
   assign width1_o = width[1];
endmodule

// File: rtl/lwn_ctrl_chk.sv
module lwn_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       retrain_i,
   input logic       merged_o,
   input logic [3:0] width0_o,
   input logic [3:0] width1_o,
   input logic [1:0] trying_o,
   input logic [1:0] trained_o,
   input logic [1:0] down_o
);
   AST_RETRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      retrain_i |=> (trying_o == 2'b00 && trained_o == 2'b00 && down_o == 2'b00 && !merged_o)); // R1

   AST_MERGE_LINK1_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      merged_o |-> (width1_o == 4'b0000 && !trying_o[1] && !trained_o[1])); // R2

   AST_WIDTH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(width0_o) && $onehot0(width1_o)); // R4

   AST_HALF_NO_X8: assert property (@(posedge clk) disable iff (!rst_n)
      !merged_o |-> (!width0_o[3] && !width1_o[3])); // R4

   AST_STEP_NARROWER: assert property (@(posedge clk) disable iff (!rst_n)
      (trying_o[0] && $past(trying_o[0]) && width0_o != $past(width0_o))
      |-> (width0_o < $past(width0_o))); // R5

   AST_TRAINED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (trained_o[0] && !retrain_i) |=> (trained_o[0] && $stable(width0_o))); // R7

   AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (down_o[0] && !retrain_i) |=> (down_o[0] && width0_o == 4'b0000)); // R8
endmodule

bind lwn_ctrl lwn_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .retrain_i (retrain_i),
   .merged_o  (merged_o),
   .width0_o  (width0_o),
   .width1_o  (width1_o),
   .trying_o  (trying_o),
   .trained_o (trained_o),
   .down_o    (down_o)
);

// File: tb/tb_lwn_ctrl.sv
`timescale 1ns/100ps
module tb_lwn_ctrl;
   localparam logic [3:0] LMASK = 4'b1101;
   localparam int ID_W  = 4;
   localparam int TMO_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             retrain_i = 1'b0;
   logic [1:0]       lane_det_i = 2'b00;
   logic [1:0]       id_vld_i = 2'b00;
   logic [ID_W-1:0]  id0_i = '0;
   logic [ID_W-1:0]  id1_i = '0;
   logic [3:0]       pmask0_i = 4'b1111;
   logic [3:0]       pmask1_i = 4'b1111;
   logic [TMO_W-1:0] tmo_i = 6'd20;
   logic [1:0]       pass_i = 2'b00;
   logic [1:0]       fail_i = 2'b00;
   logic             merged_o;
   logic [3:0]       width0_o, width1_o;
   logic [1:0]       trying_o, trained_o, down_o;

   lwn_ctrl #(.LOCAL_MASK(LMASK), .ID_W(ID_W), .TMO_W(TMO_W)) dut (
      .clk(clk), .rst_n(rst_n), .retrain_i(retrain_i), .lane_det_i(lane_det_i),
      .id_vld_i(id_vld_i), .id0_i(id0_i), .id1_i(id1_i), .pmask0_i(pmask0_i),
      .pmask1_i(pmask1_i), .tmo_i(tmo_i), .pass_i(pass_i), .fail_i(fail_i),
      .merged_o(merged_o), .width0_o(width0_o), .width1_o(width1_o),
      .trying_o(trying_o), .trained_o(trained_o), .down_o(down_o)
   );

   always #2.5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // partner model: per-link fail and silent width masks
   logic [3:0]  fail_set [2];
   logic [3:0]  silent_set [2];
   logic [15:0] wlog [2];
   int          silent_cyc [2];
   logic [3:0]  prev_w [2];
   logic        prev_try [2];
   int          pc [2];

   initial begin
      for (int k = 0; k < 2; k++) begin
         fail_set[k] = 4'b0000; silent_set[k] = 4'b0000;
         wlog[k] = '0; silent_cyc[k] = 0; prev_w[k] = '0; prev_try[k] = 1'b0; pc[k] = 0;
      end
   end

   always @(negedge clk) begin
      for (int k = 0; k < 2; k++) begin
         logic [3:0] w;
         w = (k == 0) ? width0_o : width1_o;
         if (retrain_i) begin
            wlog[k] = '0;
            silent_cyc[k] = 0;
         end
         if (trying_o[k] && prev_try[k] && w == prev_w[k]) pc[k] = pc[k] + 1;
         else pc[k] = 0;
         if (trying_o[k] && (!prev_try[k] || w != prev_w[k])) wlog[k] = {wlog[k][11:0], w};
         if (trying_o[k] && (w & silent_set[k]) != 0) silent_cyc[k] = silent_cyc[k] + 1;
         pass_i[k] = 1'b0;
         fail_i[k] = 1'b0;
         if (trying_o[k] && pc[k] == 2 && (w & silent_set[k]) == 0) begin
            if ((w & fail_set[k]) != 0) fail_i[k] = 1'b1;
            else pass_i[k] = 1'b1;
         end
         prev_w[k] = w;
         prev_try[k] = trying_o[k];
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic kick();
      @(negedge clk);
      retrain_i = 1'b1;
      @(negedge clk);
      retrain_i = 1'b0;
      chk(32'(trying_o), 0, "R1", "trying after retrain");
      chk(32'(trained_o), 0, "R1", "trained after retrain");
      chk(32'(merged_o), 0, "R1", "merged after retrain");
      repeat (150) @(negedge clk);
   endtask

   task automatic setup(input logic [1:0] det, input logic [3:0] a, input logic [3:0] b,
                        input logic [3:0] pm0, input logic [3:0] pm1);
      @(negedge clk);
      lane_det_i = det; id_vld_i = det; id0_i = a; id1_i = b;
      pmask0_i = pm0; pmask1_i = pm1;
      for (int k = 0; k < 2; k++) begin fail_set[k] = 4'b0000; silent_set[k] = 4'b0000; end
   endtask

   task automatic t_reset();
      chk(32'(merged_o), 0, "R1", "merged at reset");
      chk(32'(trying_o), 0, "R1", "trying at reset");
      chk(32'(trained_o), 0, "R1", "trained at reset");
      chk(32'(down_o), 0, "R1", "down at reset");
   endtask

   task automatic t_merge_pass();
      setup(2'b11, 4'd5, 4'd5, 4'b1111, 4'b1111);
      kick();
      chk(32'(merged_o), 1, "R2", "merged same id");
      chk(32'(width1_o), 0, "R2", "link1 idle width");
      chk(32'(trained_o), 32'b01, "R2", "only link0 trained");
      chk(32'(wlog[0]), 32'h0008, "R4", "first width x8");
      chk(32'(width0_o), 32'b1000, "R7", "held width x8");
   endtask

   task automatic t_merge_step();
      setup(2'b11, 4'd7, 4'd7, 4'b1111, 4'b1111);
      fail_set[0] = 4'b1100;
      kick();
      chk(32'(wlog[0]), 32'h0841, "R5", "step x8,x4,skip x2,x1");
      chk(32'(width0_o), 32'b0001, "R7", "x1 final");
      chk(32'(trained_o[0]), 1, "R7", "x1 counts as trained");
   endtask

   task automatic t_split();
      setup(2'b11, 4'd3, 4'd9, 4'b1111, 4'b0111);
      fail_set[1] = 4'b0100;
      kick();
      chk(32'(merged_o), 0, "R3", "not merged");
      chk(32'(wlog[0]), 32'h0004, "R4", "half0 starts x4 not x8");
      chk(32'(wlog[1]), 32'h0041, "R3", "half1 own sequence");
      chk(32'(trained_o), 32'b11, "R3", "both halves trained");
      chk(32'(width1_o), 32'b0001, "R5", "half1 x1");
   endtask

   task automatic t_timeout();
      setup(2'b11, 4'd1, 4'd2, 4'b1111, 4'b1111);
      tmo_i = 6'd5;
      silent_set[1] = 4'b0100;
      kick();
      chk(32'(silent_cyc[1]), 5, "R6", "timeout cycles at x4");
      chk(32'(wlog[1]), 32'h0041, "R6", "timeout moves to x1");
      chk(32'(trained_o[1]), 1, "R6", "trained after timeout");
      @(negedge clk);
      tmo_i = 6'd20;
   endtask

   task automatic t_linkdown();
      setup(2'b11, 4'd6, 4'd6, 4'b1111, 4'b1111);
      fail_set[0] = 4'b1111;
      kick();
      chk(32'(wlog[0]), 32'h0841, "R8", "all widths tried");
      chk(32'(down_o[0]), 1, "R8", "link down set");
      chk(32'(width0_o), 0, "R8", "width zero when down");
      repeat (30) @(negedge clk);
      chk(32'({trying_o[0], trained_o[0], down_o[0]}), 32'b001, "R8", "stays down, idle");
      fail_set[0] = 4'b0000;
      kick();
      chk(32'(trained_o[0]), 1, "R1", "retrain recovers");
      chk(32'(down_o[0]), 0, "R1", "retrain clears down");
   endtask

   task automatic t_one_half();
      setup(2'b01, 4'd4, 4'd4, 4'b1111, 4'b1111);
      kick();
      chk(32'(merged_o), 0, "R3", "single half not merged");
      chk(32'({trying_o[1], trained_o[1], down_o[1]}), 0, "R3", "undetected half idle");
      chk(32'(width0_o), 32'b0100, "R3", "detected half x4");
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_merge_pass();
      t_merge_step();
      t_split();
      t_timeout();
      t_linkdown();
      t_one_half();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule